// File: doc/BRIEF.md
# Wide-Word ALU with Dual Flag Groups

This block is the arithmetic and logic stage of a big-number datapath. Each cycle it may accept one operation on two wide operands (256 bits by default). The second operand first passes through a byte-granular shifter, or is replaced by a zero-extended immediate. The block then adds, subtracts, compares, applies a bitwise function or selects between the operands on a flag. It registers the result, pulses a write-enable for it and updates one of two independent flag groups.

A flag group holds four flags: carry, most-significant bit, least-significant bit and zero. A one-bit selector picks the group that an operation reads and writes. The other group keeps its value, so two interleaved multi-word computations can each keep their own carry chain. The register file, decode and memory access sit outside this block.

Top module: `wide_alu`

## Requirements
- R1: Operation codes are ADD=0, ADDC=1, ADDI=2, SUB=3, SUBB=4, SUBI=5, CMP=6, CMPB=7, AND=8, OR=9, XOR=10, NOT=11 and SEL=12. An operation presented with `op_valid` high is captured on the rising clock edge. Its result appears on `res_data`, with `res_we` high for exactly that one cycle, after the same edge.
- R2: ADD produces A + B' truncated to the word width. ADDC also adds the carry flag of the selected group.
- R3: SUB produces A − B'. SUBB also subtracts the carry flag of the selected group. The carry flag then holds the borrow out of the top bit.
- R4: ADDI and SUBI use the zero-extended `imm` as B'. The shift direction and amount have no effect on them.
- R5: For every other operation, B' is `opb` shifted left (`shift_right`=0) or right (`shift_right`=1) by 8 × `shift_bytes` bits, for shifts of 0 to 248 bits.
- R6: CMP and CMPB compute like SUB and SUBB and update all four flags. They leave `res_we` low and `res_data` unchanged.
- R7: AND, OR and XOR combine A with B'. NOT produces the inverse of B' and ignores A.
- R8: The bitwise operations update only M, L and Z. The carry flag of the group keeps its value.
- R9: Flag bits within a group are C=bit 0, M=bit 1, L=bit 2 and Z=bit 3. M is the result's top bit, L is its bottom bit, Z is set when the whole result is zero, and C is the carry or borrow out of the top bit.
- R10: `flag_grp` picks the group that is read and written. Group 0 is `flags_all[3:0]` and group 1 is `flags_all[7:4]`. The unselected group never changes.
- R11: SEL returns `opa` when the flag chosen by `flag_sel` (0=C, 1=M, 2=L, 3=Z) in the selected group is set, and `opb` unshifted otherwise. It writes the result and changes no flags.
- R12: Reset clears the result and both flag groups. A cycle with `op_valid` low, or an op code of 13 to 15, writes nothing and changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| opa | input | 256 | First operand |
| opb | input | 256 | Second operand |
| imm | input | 10 | Unsigned immediate for ADDI/SUBI |
| shift_right | input | 1 | Pre-shift direction for opb (1 = right) |
| shift_bytes | input | 5 | Pre-shift amount in bytes |
| flag_grp | input | 1 | Flag group index |
| flag_sel | input | 2 | Flag tested by SEL |
| res_data | output | 256 | Registered result |
| res_we | output | 1 | Result write-enable pulse |
| flags_all | output | 8 | Both flag groups, group 0 in the low nibble |

## Verification
A wrong flag register does not show on its own. It shows at `flags_all` one cycle after the operation that wrote it, and it shows again as a wrong sum when a later ADDC or SUBB takes that carry in, or as the wrong operand chosen by a SEL. The bench therefore chains carry-consuming operations and selects after the ones that set flags, so a corrupted flag shows up within one or two operations. A result that is written when it should not be, or a flag write that reaches the wrong group, shows on `res_data` or on the other nibble of `flags_all` in the cycle right after the capture edge.

// File: rtl/wal_pkg.sv
package wal_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_ADDI = 4'd2,
        OP_SUB  = 4'd3,
        OP_SUBB = 4'd4,
        OP_SUBI = 4'd5,
        OP_CMP  = 4'd6,
        OP_CMPB = 4'd7,
        OP_AND  = 4'd8,
        OP_OR   = 4'd9,
        OP_XOR  = 4'd10,
        OP_NOT  = 4'd11,
        OP_SEL  = 4'd12
    } wal_op_e;

    localparam int FLG_C = 0;
    localparam int FLG_M = 1;
    localparam int FLG_L = 2;
    localparam int FLG_Z = 3;
    localparam int FLG_N = 4;

    typedef enum logic [1:0] {
        LF_AND = 2'd0,
        LF_OR  = 2'd1,
        LF_XOR = 2'd2,
        LF_NOT = 2'd3
    } wal_lfn_e;

    typedef struct packed {
        logic     legal;
        logic     is_arith;
        logic     is_sub;
        logic     use_carry;
        logic     use_imm;
        logic     is_logic;
        logic     is_sel;
        logic     wr_res;
        wal_lfn_e lfn;
    } wal_dec_t;

endpackage

// File: rtl/wal_decode.sv
module wal_decode
    import wal_pkg::*;
(
    input  logic [3:0] op_code,
    output wal_dec_t   dec
);
    always_comb begin
        dec = '0;
        dec.lfn = LF_AND;
        case (op_code)
            OP_ADD, OP_ADDC, OP_ADDI: begin
                dec.legal     = 1'b1;
                dec.is_arith  = 1'b1;
                dec.use_carry = (op_code == OP_ADDC);
                dec.use_imm   = (op_code == OP_ADDI);
                dec.wr_res    = 1'b1;
            end
            OP_SUB, OP_SUBB, OP_SUBI: begin
                dec.legal     = 1'b1;
                dec.is_arith  = 1'b1;
                dec.is_sub    = 1'b1;
                dec.use_carry = (op_code == OP_SUBB);
                dec.use_imm   = (op_code == OP_SUBI);
                dec.wr_res    = 1'b1;
            end
            OP_CMP, OP_CMPB: begin
                dec.legal     = 1'b1;
                dec.is_arith  = 1'b1;
                dec.is_sub    = 1'b1;
                dec.use_carry = (op_code == OP_CMPB);
            end
            OP_AND, OP_OR, OP_XOR, OP_NOT: begin
                dec.legal    = 1'b1;
                dec.is_logic = 1'b1;
                dec.wr_res   = 1'b1;
                dec.lfn      = wal_lfn_e'(op_code[1:0]);
            end
            OP_SEL: begin
                dec.legal  = 1'b1;
                dec.is_sel = 1'b1;
                dec.wr_res = 1'b1;
            end
            default: dec = '0;
        endcase
    end
endmodule

// File: rtl/wal_preshift.sv
module wal_preshift #(
    parameter int W      = 256,
    parameter int AMT_W  = 5,
    parameter int STEP   = 8
) (
    input  logic [W-1:0]     din,
    input  logic             to_right,
    input  logic [AMT_W-1:0] amount,
    output logic [W-1:0]     dout
);
    localparam int BIT_AMT_W = AMT_W + $clog2(STEP);

    logic [BIT_AMT_W-1:0] bit_amt;

    always_comb begin
        bit_amt = BIT_AMT_W'(amount) * BIT_AMT_W'(STEP);
        dout    = to_right ? (din >> bit_amt) : (din << bit_amt);
    end
endmodule

// File: rtl/wal_addsub.sv
module wal_addsub #(
    parameter int W = 256
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int EW = W + 1;

    logic [EW-1:0] ext;
    logic [EW-1:0] cin_ext;

    always_comb begin
        cin_ext = EW'(cin);
        if (sub) begin
            ext = {1'b0, a} - {1'b0, b} - cin_ext;
        end else begin
            ext = {1'b0, a} + {1'b0, b} + cin_ext;
        end
        sum  = ext[W-1:0];
        cout = ext[W];
    end
endmodule

// File: rtl/wal_logic.sv
module wal_logic
    import wal_pkg::*;
#(
    parameter int W = 256
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  wal_lfn_e     fn,
    output logic [W-1:0] y
);
    always_comb begin
        case (fn)
            LF_AND:  y = a & b;
            LF_OR:   y = a | b;
            LF_XOR:  y = a ^ b;
            default: y = ~b;
        endcase
    end
endmodule

// File: rtl/wide_alu.sv
module wide_alu
    import wal_pkg::*;
#(
    parameter int W     = 256,
    parameter int IMM_W = 10,
    parameter int SHA_W = 5,
    parameter int NGRP  = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid,
    input  logic [3:0]            op_code,
    input  logic [W-1:0]          opa,
    input  logic [W-1:0]          opb,
    input  logic [IMM_W-1:0]      imm,
    input  logic                  shift_right,
    input  logic [SHA_W-1:0]      shift_bytes,
    input  logic [$clog2(NGRP)-1:0] flag_grp,
    input  logic [1:0]            flag_sel,
    output logic [W-1:0]          res_data,
    output logic                  res_we,
    output logic [NGRP*FLG_N-1:0] flags_all
);
    localparam int GRP_W = $clog2(NGRP);

    typedef struct packed {
        logic [W-1:0]                res;
        logic                        we;
        logic [NGRP-1:0][FLG_N-1:0]  flg;
    } wal_state_t;

    wal_state_t st_d, st_q;
    wal_dec_t   dec;

    logic [W-1:0]     b_shifted;
    logic [W-1:0]     b_eff;
    logic [W-1:0]     arith_y;
    logic             arith_co;
    logic [W-1:0]     logic_y;
    logic [FLG_N-1:0] grp_flags;
    logic             carry_in;

    wal_decode u_dec (
        .op_code (op_code),
        .dec     (dec)
    );

    wal_preshift #(.W(W), .AMT_W(SHA_W), .STEP(8)) u_shift (
        .din      (opb),
        .to_right (shift_right),
        .amount   (shift_bytes),
        .dout     (b_shifted)
    );

    always_comb begin
        b_eff     = dec.use_imm ? W'(imm) : b_shifted;
        grp_flags = st_q.flg[flag_grp];
        carry_in  = dec.use_carry & grp_flags[FLG_C];
    end

    wal_addsub #(.W(W)) u_arith (
        .a    (opa),
        .b    (b_eff),
        .sub  (dec.is_sub),
        .cin  (carry_in),
        .sum  (arith_y),
        .cout (arith_co)
    );

    wal_logic #(.W(W)) u_logic (
        .a  (opa),
        .b  (b_eff),
        .fn (dec.lfn),
        .y  (logic_y)
    );

    always_comb begin
        logic [W-1:0] y;
        st_d    = st_q;
        st_d.we = 1'b0;
        if (dec.is_sel) begin
            y = grp_flags[flag_sel] ? opa : opb;
        end else if (dec.is_logic) begin
            y = logic_y;
        end else begin
            y = arith_y;
        end
        if (op_valid && dec.legal && (32'(flag_grp) < NGRP)) begin
            st_d.we = dec.wr_res;
            if (dec.wr_res) begin
                st_d.res = y;
            end
            if (dec.is_arith || dec.is_logic) begin
                st_d.flg[flag_grp][FLG_M] = y[W-1];
                st_d.flg[flag_grp][FLG_L] = y[0];
                st_d.flg[flag_grp][FLG_Z] = (y == '0);
            end
            if (dec.is_arith) begin
                st_d.flg[flag_grp][FLG_C] = arith_co;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_data  = st_q.res;
    assign res_we    = st_q.we;
    assign flags_all = st_q.flg;

endmodule

// File: rtl/wide_alu_chk.sv
module wide_alu_chk
    import wal_pkg::*;
#(
    parameter int W    = 256,
    parameter int NGRP = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  op_valid,
    input logic [3:0]            op_code,
    input logic [$clog2(NGRP)-1:0] flag_grp,
    input logic [W-1:0]          res_data,
    input logic                  res_we,
    input logic [NGRP*FLG_N-1:0] flags_all
);
    localparam int G1_LO = FLG_N;
    localparam int G1_HI = 2 * FLG_N - 1;

    // R1
    we_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_we |-> $past(op_valid));

    // R12
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_all));

    // R12
    idle_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_we && $stable(res_data)));

    // R6
    cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == OP_CMP || op_code == OP_CMPB))
        |=> (!res_we && $stable(res_data)));

    // R8
    logic_carry_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= OP_AND && op_code <= OP_NOT && flag_grp == '0)
        |=> (flags_all[FLG_C] == $past(flags_all[FLG_C])));

    // R11
    sel_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SEL) |=> ($stable(flags_all) && res_we));

    // R10
    grp_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && flag_grp == '0) |=> $stable(flags_all[G1_HI:G1_LO]));

    // R9
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we && $past(op_code == OP_ADD && flag_grp == '0))
        |-> (flags_all[FLG_Z] == (res_data == '0)));

endmodule

bind wide_alu wide_alu_chk #(.W(W), .NGRP(NGRP)) i_wide_alu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .flag_grp  (flag_grp),
    .res_data  (res_data),
    .res_we    (res_we),
    .flags_all (flags_all)
);

// File: tb/test_wide_alu.sv
module test_wide_alu;
    localparam int W = 256;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_code = '0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic [9:0]   imm = '0;
    logic         shift_right = 1'b0;
    logic [4:0]   shift_bytes = '0;
    logic         flag_grp = 1'b0;
    logic [1:0]   flag_sel = '0;
    logic [W-1:0] res_data;
    logic         res_we;
    logic [7:0]   flags_all;

    wide_alu i_wide_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .opa(opa), .opb(opb), .imm(imm), .shift_right(shift_right),
        .shift_bytes(shift_bytes), .flag_grp(flag_grp), .flag_sel(flag_sel),
        .res_data(res_data), .res_we(res_we), .flags_all(flags_all)
    );

    always #10 clk = ~clk;

    typedef struct {
        int           cyc;
        logic         we;
        logic [W-1:0] data;
        logic [7:0]   flg;
        string        tag;
    } exp_t;

    exp_t         exp_q[$];
    int           cyc_cnt = 0;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;
    logic [W-1:0] m_res = '0;
    logic [7:0]   m_flg = '0;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    // monitor: compares one cycle after each issue
    always @(negedge clk) begin
        if (exp_q.size() > 0 && exp_q[0].cyc < cyc_cnt) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (res_we !== e.we || res_data !== e.data || flags_all !== e.flg) begin
                errors++;
                $display("FAIL %s: we=%0b data=%h flags=%b expected we=%0b data=%h flags=%b",
                         e.tag, res_we, res_data, flags_all, e.we, e.data, e.flg);
            end
        end
    end

    task automatic issue(input logic vld, input logic [3:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic [9:0] im, input logic rt,
                         input logic [4:0] sb, input logic g, input logic [1:0] fs,
                         input string tag);
        logic [W:0]   ext;
        logic [W-1:0] bb, y;
        logic         c;
        logic         we;
        int           base;
        @(negedge clk);
        op_valid = vld; op_code = op; opa = a; opb = b; imm = im;
        shift_right = rt; shift_bytes = sb; flag_grp = g; flag_sel = fs;
        base = g ? 4 : 0;
        c  = m_flg[base];
        bb = (op == 4'd2 || op == 4'd5) ? W'(im)
           : (rt ? (b >> (int'(sb) * 8)) : (b << (int'(sb) * 8)));
        we = 1'b0;
        y  = '0;
        if (vld) begin
            case (op)
                4'd0, 4'd1, 4'd2: begin
                    ext = {1'b0, a} + {1'b0, bb} + ((op == 4'd1) ? (W+1)'(c) : '0);
                    y = ext[W-1:0]; we = 1'b1;
                    m_flg[base] = ext[W];
                end
                4'd3, 4'd4, 4'd5, 4'd6, 4'd7: begin
                    ext = {1'b0, a} - {1'b0, bb}
                        - ((op == 4'd4 || op == 4'd7) ? (W+1)'(c) : '0);
                    y = ext[W-1:0]; we = (op < 4'd6);
                    m_flg[base] = ext[W];
                end
                4'd8:  begin y = a & bb; we = 1'b1; end
                4'd9:  begin y = a | bb; we = 1'b1; end
                4'd10: begin y = a ^ bb; we = 1'b1; end
                4'd11: begin y = ~bb;    we = 1'b1; end
                4'd12: begin y = m_flg[base + int'(fs)] ? a : b; we = 1'b1; end
                default: ;
            endcase
            if (op <= 4'd11) begin
                m_flg[base+1] = y[W-1];
                m_flg[base+2] = y[0];
                m_flg[base+3] = (y == '0);
            end
            if (we) m_res = y;
        end
        exp_q.push_back('{cyc_cnt, we, m_res, m_flg, tag});
    endtask

    logic [W-1:0] ones = '1;
    logic [W-1:0] pat  = {8{32'hA5C3_0F81}};
    logic [W-1:0] big  = {4{64'h1234_5678_9ABC_DEF0}};

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res_we !== 1'b0 || res_data !== '0 || flags_all !== 8'h00) begin
            errors++;
            $display("FAIL R12 reset: we=%0b data=%h flags=%b expected 0 0 0",
                     res_we, res_data, flags_all);
        end
        rst_n = 1'b1;
        // R1 R2 R9 basic add and overflow to zero
        issue(1, 4'd0, 256'd5, 256'd7, 0, 0, 0, 0, 0, "R1 R2 add");
        issue(1, 4'd0, ones, 256'd1, 0, 0, 0, 0, 0, "R2 R9 add wrap");
        // R2 add with carry consumes C=1
        issue(1, 4'd1, big, pat, 0, 0, 0, 0, 0, "R2 addc");
        // R3 borrow then subb
        issue(1, 4'd3, 256'd5, 256'd7, 0, 0, 0, 0, 0, "R3 sub borrow");
        issue(1, 4'd4, big, 256'd1, 0, 0, 0, 0, 0, "R3 subb");
        issue(1, 4'd4, big, 256'd1, 0, 0, 0, 0, 0, "R3 subb no borrow");
        // R4 immediates ignore shift
        issue(1, 4'd2, big, ones, 10'h3FF, 0, 5'd3, 0, 0, "R4 addi");
        issue(1, 4'd5, 256'd2, ones, 10'h3, 1, 5'd7, 0, 0, "R4 subi");
        // R5 pre-shift
        issue(1, 4'd0, 256'd0, pat, 0, 0, 5'd31, 0, 0, "R5 shl 248");
        issue(1, 4'd0, 256'd1, pat, 0, 1, 5'd1, 0, 0, "R5 shr 8");
        issue(1, 4'd10, 256'd0, big, 0, 1, 5'd31, 0, 0, "R5 shr 248");
        // R6 compares
        issue(1, 4'd6, 256'd3, 256'd9, 0, 0, 0, 0, 0, "R6 cmp");
        issue(1, 4'd7, 256'd9, 256'd3, 0, 0, 0, 0, 0, "R6 cmpb");
        // R7 R8 R10 logic in group 1 after a borrow in group 1
        issue(1, 4'd3, 256'd0, 256'd1, 0, 0, 0, 1, 0, "R10 sub grp1");
        issue(1, 4'd8, pat, big, 0, 0, 0, 1, 0, "R7 R8 and");
        issue(1, 4'd9, pat, big, 0, 0, 5'd2, 1, 0, "R7 or");
        issue(1, 4'd10, pat, pat, 0, 0, 0, 1, 0, "R7 R8 xor zero");
        issue(1, 4'd11, ones, ones, 0, 0, 0, 1, 0, "R7 not");
        issue(1, 4'd11, 256'd0, 256'd1, 0, 0, 5'd1, 0, 0, "R7 not shifted");
        // R11 select on each flag of both groups
        issue(1, 4'd12, pat, big, 0, 1, 5'd4, 1, 0, "R11 sel C");
        issue(1, 4'd12, pat, big, 0, 0, 0, 1, 1, "R11 sel M");
        issue(1, 4'd12, pat, big, 0, 0, 0, 1, 2, "R11 sel L");
        issue(1, 4'd12, pat, big, 0, 0, 0, 1, 3, "R11 sel Z");
        issue(1, 4'd12, pat, big, 0, 0, 0, 0, 3, "R11 sel grp0 Z");
        // R10 carry chains separate per group
        issue(1, 4'd1, 256'd0, 256'd0, 0, 0, 0, 1, 0, "R10 addc grp1");
        issue(1, 4'd1, 256'd0, 256'd0, 0, 0, 0, 0, 0, "R10 addc grp0");
        // R12 ignored cycles
        issue(1, 4'd13, pat, big, 0, 0, 0, 0, 0, "R12 illegal op");
        issue(0, 4'd0, ones, ones, 0, 0, 0, 0, 0, "R12 valid low");
        issue(1, 4'd15, ones, ones, 0, 0, 0, 1, 0, "R12 illegal op grp1");
        @(negedge clk);
        op_valid = 1'b0;
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1 queue: %0d left expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: run hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule